// File: doc/BRIEF.md
# Text Character Cell Renderer

This block draws one text character into a frame buffer that stores one byte per pixel. A caller gives it a character code, the column and row of a character cell on the screen, and two colours, then pulses a start strobe. The renderer looks up the glyph of that code in an internal font table and writes all 128 pixels of the 8-wide by 16-tall cell. Pixels whose glyph bit is set get the foreground colour. Pixels whose glyph bit is clear get the background colour.

Each pixel leaves the block as its own write request on a request/acknowledge memory port. The renderer holds each request until the memory accepts it, so it can sit behind an arbiter that shares the frame buffer with other masters. When the last pixel has been accepted, a one-cycle done pulse tells the caller that the cell is complete and that a new start will be taken.

The font table is computed inside the block, so no initialisation file is needed. The table can be read through a register or combinationally, chosen by a parameter.

Top module: `char_cell_render`

## Requirements
- R1: The font table holds 16 bytes per code. Row r (0 is the top row) of code c sits at table index c*16+r. Its content is ((c*29) xor (r*17) xor 0x5A) taken modulo 256.
- R2: Within a glyph row byte, pixel column k (0 is the leftmost column) takes bit 7-k, so the most significant bit is drawn leftmost.
- R3: A set glyph bit writes the foreground colour, and a clear glyph bit writes the background colour. Both colours are captured on the accepted start.
- R4: The pixel at glyph row r and column k of cell (x, y) is written to address (y*16+r)*LINE_W + x*8 + k.
- R5: One render issues exactly 128 writes, in raster order: rows from top to bottom, and columns from left to right within each row.
- R6: A write request stays asserted, with its address and data unchanged, until wr_ack is seen high in the same cycle. Only then does the renderer move to the next pixel.
- R7: done is high for exactly one cycle, in the cycle after the 128th accepted write. No request is active during that cycle.
- R8: A start strobe that arrives while a render is in progress is ignored. It does not change the cell being drawn, and it does not cause a second render.
- R9: After reset, wr_req and done are low and the block waits for start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin rendering one cell; taken only when the block is idle |
| char_code | input | CODE_W | Character code to draw |
| cell_x | input | CX_W | Cell column |
| cell_y | input | CY_W | Cell row |
| fg_color | input | PIX_W | Colour for set glyph bits |
| bg_color | input | PIX_W | Colour for clear glyph bits |
| wr_req | output | 1 | Pixel write request |
| wr_addr | output | ADDR_W | Frame-buffer byte address of the pixel |
| wr_data | output | PIX_W | Pixel colour |
| wr_ack | input | 1 | Memory accepts the pending write |
| done | output | 1 | One-cycle pulse when the cell is finished |

## Verification
The bench builds the renderer with a line width of 64 pixels, an 8 by 4 cell grid, a 12-bit address and the registered font table. With these values the last cell of the grid and the top of the address range are reached in a few renders, and the one-cycle table latency is included in every row fetch. The memory model acknowledges with zero, one and three cycles of delay. The zero-delay case gives back-to-back acceptance, and the longer delays show that a pending request is held. Codes 0, 65 and 127 give glyph rows with bits both set and clear in the leftmost and rightmost columns.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   // Glyph cell geometry
   localparam int GLYPH_W = 8;
   localparam int GLYPH_H = 16;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_EMIT,
      ST_DONE
   } ccr_state_e;

   // Synthetic font content: row byte for code c, glyph row r
   function automatic logic [7:0] glyph_row_fn(int unsigned code, int unsigned row);
      int unsigned v;
      v = (code * 29) ^ (row * 17) ^ 32'h5A;
      return v[7:0];
   endfunction

endpackage

// File: rtl/ccr_glyph_rom.sv
module ccr_glyph_rom #(
   parameter int CODE_W  = 7,
   parameter int LATENCY = 1,
   parameter int ROW_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [ROW_W-1:0]  row,
   output logic [7:0]        data
);
   import ccr_pkg::*;

   localparam int DEPTH = (2 ** CODE_W) * GLYPH_H;
   localparam int IDX_W = CODE_W + ROW_W;

   if (LATENCY < 0 || LATENCY > 1) begin : g_bad_latency
      $error("ccr_glyph_rom: LATENCY must be 0 or 1");
   end
   if ((2 ** ROW_W) != GLYPH_H) begin : g_bad_row_w
      $error("ccr_glyph_rom: ROW_W must address exactly GLYPH_H rows");
   end

   logic [7:0]       table_w [DEPTH];
   logic [IDX_W-1:0] idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_fill
      assign table_w[i] = glyph_row_fn(i / GLYPH_H, i % GLYPH_H);
   end

   assign idx = {code, row};

   if (LATENCY == 0) begin : g_comb
      assign data = table_w[idx];
   end else begin : g_reg
      logic [7:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_q <= '0;
         else        data_q <= table_w[idx];
      end
      assign data = data_q;
   end

endmodule

// File: rtl/ccr_addr_gen.sv
module ccr_addr_gen #(
   parameter int LINE_W = 640,
   parameter int CX_W   = 7,
   parameter int CY_W   = 5,
   parameter int ROW_W  = 4,
   parameter int COL_W  = 3,
   parameter int ADDR_W = 19
) (
   input  logic [CX_W-1:0]   cx,
   input  logic [CY_W-1:0]   cy,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   output logic [ADDR_W-1:0] addr
);
   import ccr_pkg::*;

   localparam logic [ADDR_W-1:0] GH_A = ADDR_W'(GLYPH_H);
   localparam logic [ADDR_W-1:0] GW_A = ADDR_W'(GLYPH_W);
   localparam logic [ADDR_W-1:0] LW_A = ADDR_W'(LINE_W);

   logic [ADDR_W-1:0] line_idx;
   logic [ADDR_W-1:0] x_off;

   always_comb begin
      line_idx = ADDR_W'(cy) * GH_A + ADDR_W'(row);
      x_off    = ADDR_W'(cx) * GW_A + ADDR_W'(col);
      addr     = line_idx * LW_A + x_off;
   end

endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl #(
   parameter int CODE_W  = 7,
   parameter int CX_W    = 7,
   parameter int CY_W    = 5,
   parameter int PIX_W   = 8,
   parameter int ROM_LAT = 1,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] char_code,
   input  logic [CX_W-1:0]   cell_x,
   input  logic [CY_W-1:0]   cell_y,
   input  logic [PIX_W-1:0]  fg_color,
   input  logic [PIX_W-1:0]  bg_color,
   input  logic [7:0]        rom_data,
   input  logic              wr_ack,
   output logic [CODE_W-1:0] rom_code,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic [CX_W-1:0]   cx,
   output logic [CY_W-1:0]   cy,
   output logic              wr_req,
   output logic [PIX_W-1:0]  wr_data,
   output logic              done
);
   import ccr_pkg::*;

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(GLYPH_H - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(GLYPH_W - 1);
   localparam logic             WAIT_END = 1'(ROM_LAT);

   ccr_state_e        state_q;
   logic [CODE_W-1:0] code_q;
   logic [CX_W-1:0]   cx_q;
   logic [CY_W-1:0]   cy_q;
   logic [PIX_W-1:0]  fg_q;
   logic [PIX_W-1:0]  bg_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [7:0]        bits_q;
   logic              wait_q;
   logic [7:0]        shifted;
   logic              accept;

   assign accept = (state_q == ST_EMIT) && wr_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= '0;
         cx_q    <= '0;
         cy_q    <= '0;
         fg_q    <= '0;
         bg_q    <= '0;
         row_q   <= '0;
         col_q   <= '0;
         bits_q  <= '0;
         wait_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  code_q  <= char_code;
                  cx_q    <= cell_x;
                  cy_q    <= cell_y;
                  fg_q    <= fg_color;
                  bg_q    <= bg_color;
                  row_q   <= '0;
                  col_q   <= '0;
                  wait_q  <= 1'b0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (wait_q == WAIT_END) begin
                  bits_q  <= rom_data;
                  col_q   <= '0;
                  state_q <= ST_EMIT;
               end else begin
                  wait_q <= 1'b1;
               end
            end
            ST_EMIT: begin
               if (accept) begin
                  if (col_q == COL_LAST) begin
                     if (row_q == ROW_LAST) begin
                        state_q <= ST_DONE;
                     end else begin
                        row_q   <= row_q + 1'b1;
                        wait_q  <= 1'b0;
                        state_q <= ST_LOAD;
                     end
                  end else begin
                     col_q <= col_q + 1'b1;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Pixel column k maps to bit 7-k: shift left and take the top bit
   assign shifted  = bits_q << col_q;
   assign wr_data  = shifted[7] ? fg_q : bg_q;
   assign wr_req   = (state_q == ST_EMIT);
   assign done     = (state_q == ST_DONE);
   assign rom_code = code_q;
   assign row      = row_q;
   assign col      = col_q;
   assign cx       = cx_q;
   assign cy       = cy_q;

   // Pending write holds its contents until accepted
   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data) && $stable(row) && $stable(col)));

   // Done lasts a single cycle and carries no request
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_req);

   // Start while busy leaves the captured cell untouched
   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != ST_IDLE) |=>
         ($stable(code_q) && $stable(cx_q) && $stable(cy_q) && $stable(fg_q) && $stable(bg_q)));

   // Colour follows the glyph bit
   assert_colour_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && fg_q != bg_q) |-> (wr_data == fg_q || wr_data == bg_q));

endmodule

// File: rtl/char_cell_render.sv
module char_cell_render #(
   parameter int LINE_W  = 640,
   parameter int COLS    = 80,
   parameter int ROWS    = 30,
   parameter int CODE_W  = 7,
   parameter int PIX_W   = 8,
   parameter int ADDR_W  = 19,
   parameter int ROM_LAT = 1,
   parameter int CX_W    = $clog2(COLS),
   parameter int CY_W    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] char_code,
   input  logic [CX_W-1:0]   cell_x,
   input  logic [CY_W-1:0]   cell_y,
   input  logic [PIX_W-1:0]  fg_color,
   input  logic [PIX_W-1:0]  bg_color,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [PIX_W-1:0]  wr_data,
   input  logic              wr_ack,
   output logic              done
);
   import ccr_pkg::*;

   localparam int ROW_W    = $clog2(GLYPH_H);
   localparam int COL_W    = $clog2(GLYPH_W);
   localparam int FB_BYTES = LINE_W * ROWS * GLYPH_H;
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(GLYPH_W - 1);

   if (COLS < 2 || ROWS < 2) begin : g_bad_grid
      $error("char_cell_render: grid needs at least 2 columns and 2 rows");
   end
   if (LINE_W < COLS * GLYPH_W) begin : g_bad_line
      $error("char_cell_render: LINE_W too small for COLS cells");
   end
   if (FB_BYTES > 2 ** ADDR_W) begin : g_bad_addr
      $error("char_cell_render: ADDR_W cannot reach the whole frame buffer");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("char_cell_render: PIX_W must be positive");
   end

   logic [CODE_W-1:0] rom_code;
   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;
   logic [CX_W-1:0]   cx;
   logic [CY_W-1:0]   cy;
   logic [7:0]        rom_data;

   ccr_glyph_rom #(
      .CODE_W (CODE_W),
      .LATENCY(ROM_LAT),
      .ROW_W  (ROW_W)
   ) u_rom (
      .clk  (clk),
      .rst_n(rst_n),
      .code (rom_code),
      .row  (row),
      .data (rom_data)
   );

   ccr_ctrl #(
      .CODE_W (CODE_W),
      .CX_W   (CX_W),
      .CY_W   (CY_W),
      .PIX_W  (PIX_W),
      .ROM_LAT(ROM_LAT),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .char_code(char_code),
      .cell_x   (cell_x),
      .cell_y   (cell_y),
      .fg_color (fg_color),
      .bg_color (bg_color),
      .rom_data (rom_data),
      .wr_ack   (wr_ack),
      .rom_code (rom_code),
      .row      (row),
      .col      (col),
      .cx       (cx),
      .cy       (cy),
      .wr_req   (wr_req),
      .wr_data  (wr_data),
      .done     (done)
   );

   ccr_addr_gen #(
      .LINE_W(LINE_W),
      .CX_W  (CX_W),
      .CY_W  (CY_W),
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .ADDR_W(ADDR_W)
   ) u_addr (
      .cx  (cx),
      .cy  (cy),
      .row (row),
      .col (col),
      .addr(wr_addr)
   );

   // Every write lands inside the frame buffer
   assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (32'(wr_addr) < FB_BYTES));

   // Within a glyph row, consecutive accepted pixels are adjacent bytes
   assert_raster_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ack && col != COL_LAST) |=> (wr_req && wr_addr == $past(wr_addr) + 1'b1));

   // Address of a pending write does not move
   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> $stable(wr_addr));

endmodule

// File: tb/sim_char_cell_render.sv
module sim_char_cell_render;

   localparam int LINE_W = 64;
   localparam int COLS   = 8;
   localparam int ROWS   = 4;
   localparam int CODE_W = 7;
   localparam int PIX_W  = 8;
   localparam int ADDR_W = 12;
   localparam int CX_W   = 3;
   localparam int CY_W   = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CODE_W-1:0] char_code = '0;
   logic [CX_W-1:0]   cell_x = '0;
   logic [CY_W-1:0]   cell_y = '0;
   logic [PIX_W-1:0]  fg_color = '0;
   logic [PIX_W-1:0]  bg_color = '0;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [PIX_W-1:0]  wr_data;
   logic              wr_ack = 1'b0;
   logic              done;

   int n_checks = 0;
   int n_fail   = 0;

   int resp_delay = 0;
   int resp_cnt   = 0;
   int done_count = 0;
   int writes_at_done = -1;
   int hold_errs  = 0;
   logic              prev_wait = 1'b0;
   logic [ADDR_W-1:0] prev_addr = '0;
   logic [PIX_W-1:0]  prev_data = '0;
   logic [ADDR_W-1:0] log_addr[$];
   logic [PIX_W-1:0]  log_data[$];

   always #4 clk = ~clk;

   char_cell_render #(
      .LINE_W (LINE_W),
      .COLS   (COLS),
      .ROWS   (ROWS),
      .CODE_W (CODE_W),
      .PIX_W  (PIX_W),
      .ADDR_W (ADDR_W),
      .ROM_LAT(1),
      .CX_W   (CX_W),
      .CY_W   (CY_W)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .char_code(char_code),
      .cell_x   (cell_x),
      .cell_y   (cell_y),
      .fg_color (fg_color),
      .bg_color (bg_color),
      .wr_req   (wr_req),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_ack   (wr_ack),
      .done     (done)
   );

   // Memory model and monitor, both on the falling edge
   always @(negedge clk) begin
      if (done) begin
         done_count++;
         writes_at_done = log_addr.size();
      end
      if (prev_wait && wr_req && (wr_addr != prev_addr || wr_data != prev_data))
         hold_errs++;
      if (prev_wait && !wr_req) hold_errs++;
      if (wr_req && resp_cnt >= resp_delay) begin
         wr_ack = 1'b1;
         log_addr.push_back(wr_addr);
         log_data.push_back(wr_data);
         resp_cnt = 0;
         prev_wait = 1'b0;
      end else begin
         wr_ack = 1'b0;
         if (wr_req) begin
            resp_cnt++;
            prev_wait = 1'b1;
            prev_addr = wr_addr;
            prev_data = wr_data;
         end else begin
            prev_wait = 1'b0;
         end
      end
   end

   function automatic logic [7:0] exp_row(int code, int r);
      int v;
      v = (code * 29) ^ (r * 17) ^ 32'h5A;
      return v[7:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input int code, input int x, input int y,
                              input int fg, input int bg);
      @(negedge clk);
      char_code = CODE_W'(code);
      cell_x    = CX_W'(x);
      cell_y    = CY_W'(y);
      fg_color  = PIX_W'(fg);
      bg_color  = PIX_W'(bg);
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      int t = 0;
      seen = 1'b0;
      while (t < 3000 && done_count == 0) begin
         @(posedge clk);
         t++;
      end
      seen = (done_count != 0);
      if (!seen) begin
         n_checks++;
         n_fail++;
         $display("FAIL R7 watchdog: no done after %0d cycles", t);
      end
   endtask

   task automatic clear_logs();
      log_addr.delete();
      log_data.delete();
      done_count = 0;
      writes_at_done = -1;
      hold_errs = 0;
   endtask

   task automatic verify_cell(input int code, input int x, input int y,
                              input int fg, input int bg);
      int addr_bad = 0;
      int data_bad = 0;
      int first_bad = -1;
      int n = log_addr.size();
      check(n == 128, "R5", "write count", n, 128);
      for (int k = 0; k < 128 && k < n; k++) begin
         int r = k / 8;
         int c = k % 8;
         int ea = (y * 16 + r) * LINE_W + x * 8 + c;
         logic [7:0] rb = exp_row(code, r);
         int ed = rb[7 - c] ? fg : bg;
         if (int'(log_addr[k]) != ea) begin
            addr_bad++;
            if (first_bad < 0) first_bad = k;
         end
         if (int'(log_data[k]) != ed) data_bad++;
      end
      check(addr_bad == 0, "R4", "address mismatches", addr_bad, 0);
      check(data_bad == 0, "R1/R2/R3", "pixel colour mismatches", data_bad, 0);
      check(done_count == 1, "R7", "done pulses", done_count, 1);
      check(writes_at_done == 128, "R7", "writes before done", writes_at_done, 128);
      check(hold_errs == 0, "R6", "pending request changes", hold_errs, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(wr_req == 1'b0, "R9", "wr_req after reset", int'(wr_req), 0);
      check(done == 1'b0, "R9", "done after reset", int'(done), 0);
   endtask

   task automatic t_render(input int code, input int x, input int y,
                           input int fg, input int bg, input int dly);
      bit seen;
      resp_delay = dly;
      clear_logs();
      pulse_start(code, x, y, fg, bg);
      wait_done(seen);
      repeat (3) @(negedge clk);
      verify_cell(code, x, y, fg, bg);
   endtask

   // R8: a second start during the render must not change or repeat it
   task automatic t_busy_start();
      bit seen;
      resp_delay = 1;
      clear_logs();
      pulse_start(33, 5, 2, 8'h3C, 8'hC3);
      repeat (20) @(negedge clk);
      pulse_start(90, 1, 0, 8'h11, 8'h22);
      wait_done(seen);
      repeat (40) @(negedge clk);
      check(log_addr.size() == 128, "R8", "writes after busy start",
            log_addr.size(), 128);
      check(done_count == 1, "R8", "renders after busy start", done_count, 1);
      verify_cell(33, 5, 2, 8'h3C, 8'hC3);
   endtask

   initial begin
      #(8ns * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_render(65, 0, 0, 8'hF0, 8'h0F, 0);
      t_render(127, 7, 3, 8'h05, 8'hE7, 3);
      t_render(0, 3, 1, 8'hAA, 8'h55, 1);
      t_busy_start();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule